// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This combinational block sits between a core and a memory that is one word wide with one write-enable per byte. On the store side, it turns a store request into a per-byte write-enable mask. It also moves the low bytes of the store operand into the lanes picked by the byte offset. On the load side, it takes the fetched word and moves the addressed byte, halfword or word down to bit 0. It then widens the result to the full register width, using the sign bit or zeros as the access type requires.

The access size and the signedness come from the three-bit access-type field of a load or store instruction. Bits [1:0] give the size: 00 is a byte, 01 is a halfword, 10 is a word and 11 is not used. Bit [2] set means unsigned. The byte offset is the low two bits of the byte address. Alignment traps and memory timing are handled elsewhere.

Top module: `lane_aligner`

## Requirements
- R1: For a store with size code 00, `writeMask` has exactly one bit set, at position `byteOff`: 0001, 0010, 0100 or 1000.
- R2: For a store with size code 01, `writeMask` is 0011 shifted left by `byteOff` and cut to 4 bits. Offset 0 gives 0011, offset 1 gives 0110, offset 2 gives 1100 and offset 3 gives 1000.
- R3: For a store with size code 10, `writeMask` is 1111 shifted left by `byteOff` and cut to 4 bits. Offset 0 gives 1111.
- R4: While `storeEn` is 0, `writeMask` is 0000 whatever the other inputs are.
- R5: `writeData` equals `storeData` shifted left by 8 times `byteOff`, cut to 32 bits, so the selected lanes carry the low bytes of `storeData`.
- R6: For size code 00 with `accType[2]`=0, `loadValue` is the byte at lane `byteOff` of `readWord`, with its bit 7 copied into bits [31:8].
- R7: With `accType[2]`=1, a byte or halfword load fills every bit above the extracted field with 0.
- R8: For size code 01 with `accType[2]`=0, `loadValue` is the 16 bits of `readWord` starting at bit 8 times `byteOff`, with bit 15 of that field copied into bits [31:16]. Only offsets 0 and 2 are tested.
- R9: For size code 10, `loadValue` is `readWord` shifted right by 8 times `byteOff`. At offset 0 this is the whole word.
- R10: Size code 11 gives `writeMask` = 0000 and `loadValue` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| storeEn | input | 1 | Store request qualifier |
| accType | input | 3 | Access type: [1:0] size, [2] unsigned |
| byteOff | input | 2 | Low bits of the byte address |
| storeData | input | 32 | Store operand before lane placement |
| readWord | input | 32 | Word returned by memory |
| writeMask | output | 4 | Per-byte write enables |
| writeData | output | 32 | Lane-placed store data |
| loadValue | output | 32 | Extracted and extended load result |

## Verification
The read word used for the tests has bytes with the sign bit set and bytes with it clear, at every lane. This shows whether sign extension uses the right bit and whether the lane shift goes the right way. Every size is tried at every offset, once as a store and once with the store flag off, so that the mask shape and its gating are checked separately. Signed and unsigned loads read the same bytes, which isolates the extension rule. The store operand has a distinct byte in each lane, so any misplaced lane in `writeData` shows up.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_NONE = 2'b11
  } lsaSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     writeOn;
    lsaSize_e size;
    logic     zeroExt;
  } lsaStrobe_t;
endpackage

// File: rtl/lsa_ctrl.sv
module lsa_ctrl
  import lsa_pkg::*;
(
  input  logic       storeEn,
  input  logic [2:0] accType,
  output lsaStrobe_t strobe
);
  always_comb begin
    strobe.writeOn = storeEn;
    strobe.size    = lsaSize_e'(accType[1:0]);
    strobe.zeroExt = accType[2];
  end

  // R4: a write is only ever offered when a store is requested
  always_comb begin
    if (!$isunknown({storeEn, accType}))
      p_write_gated_r4: assert (storeEn || !strobe.writeOn)
        else $error("strobe asks for a write without a store");
  end
endmodule

// File: rtl/lsa_datapath.sv
module lsa_datapath
  import lsa_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  lsaStrobe_t            strobe,
  input  logic [$clog2(DATA_W/8)-1:0] laneOff,
  input  logic [DATA_W-1:0]     storeData,
  input  logic [DATA_W-1:0]     readWord,
  output logic [DATA_W/8-1:0]   writeMask,
  output logic [DATA_W-1:0]     writeData,
  output logic [DATA_W-1:0]     loadValue
);
  localparam int unsigned LANES = DATA_W / 8;
  localparam int unsigned OFF_W = $clog2(LANES);
  localparam int unsigned SH_W  = OFF_W + 3;

  logic [LANES-1:0]  baseMask;
  logic [SH_W-1:0]   bitShift;
  logic [DATA_W-1:0] aligned;
  logic              fillBit;

  assign bitShift = {laneOff, 3'b000};

  // lane pattern per size before the offset shift
  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    if (lane == 0) begin : g_first
      assign baseMask[lane] = (strobe.size != SZ_NONE);
    end else if (lane == 1) begin : g_second
      assign baseMask[lane] = (strobe.size == SZ_HALF) || (strobe.size == SZ_WORD);
    end else begin : g_upper
      assign baseMask[lane] = (strobe.size == SZ_WORD);
    end
  end

  always_comb begin
    writeMask = (baseMask << laneOff) & {LANES{strobe.writeOn}};
    writeData = storeData << bitShift;
    aligned   = readWord >> bitShift;
  end

  always_comb begin
    fillBit = 1'b0;
    unique case (strobe.size)
      SZ_BYTE: begin
        fillBit   = aligned[7] & ~strobe.zeroExt;
        loadValue = {{(DATA_W-8){fillBit}}, aligned[7:0]};
      end
      SZ_HALF: begin
        fillBit   = aligned[15] & ~strobe.zeroExt;
        loadValue = {{(DATA_W-16){fillBit}}, aligned[15:0]};
      end
      SZ_WORD: loadValue = aligned;
      default: loadValue = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown({strobe, laneOff, readWord})) begin
      // R4: no lanes are enabled without a store
      p_no_write_idle_r4: assert (strobe.writeOn || writeMask == '0)
        else $error("mask active without store");
      // R1: a byte store touches exactly one lane
      p_byte_one_lane_r1: assert (!(strobe.writeOn && strobe.size == SZ_BYTE)
                                  || $countones(writeMask) == 1)
        else $error("byte store mask not one-hot");
      // R10: the unused size writes nothing and reads zero
      p_unused_size_r10: assert (strobe.size != SZ_NONE
                                 || (writeMask == '0 && loadValue == '0))
        else $error("unused size produced activity");
      // R7: unsigned narrow loads have a clear top half
      p_zero_fill_r7: assert (!(strobe.zeroExt && strobe.size != SZ_WORD)
                              || loadValue[DATA_W-1:16] == '0)
        else $error("unsigned load has set upper bits");
      // R6: signed byte loads have uniform upper bits
      p_sign_fill_r6: assert (!(strobe.size == SZ_BYTE && !strobe.zeroExt)
                              || loadValue[DATA_W-1:8] == '0
                              || loadValue[DATA_W-1:8] == '1)
        else $error("signed byte load upper bits mixed");
    end
  end
endmodule

// File: rtl/lane_aligner.sv
module lane_aligner
  import lsa_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                        storeEn,
  input  logic [2:0]                  accType,
  input  logic [$clog2(DATA_W/8)-1:0] byteOff,
  input  logic [DATA_W-1:0]           storeData,
  input  logic [DATA_W-1:0]           readWord,
  output logic [DATA_W/8-1:0]         writeMask,
  output logic [DATA_W-1:0]           writeData,
  output logic [DATA_W-1:0]           loadValue
);
  lsaStrobe_t strobe;

  lsa_ctrl u_ctrl (
    .storeEn (storeEn),
    .accType (accType),
    .strobe  (strobe)
  );

  lsa_datapath #(.DATA_W(DATA_W)) u_dp (
    .strobe    (strobe),
    .laneOff   (byteOff),
    .storeData (storeData),
    .readWord  (readWord),
    .writeMask (writeMask),
    .writeData (writeData),
    .loadValue (loadValue)
  );
endmodule

// File: tb/sim_lane_aligner.sv
module sim_lane_aligner;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [31:0] RD_PAT = 32'h80F17F85;
  localparam logic [31:0] ST_PAT = 32'hA1B2C3D4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic storeEn;
  logic [2:0] accType;
  logic [1:0] byteOff;
  logic [31:0] storeData, readWord;
  logic [3:0] writeMask;
  logic [31:0] writeData, loadValue;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_aligner u0 (
    .storeEn(storeEn), .accType(accType), .byteOff(byteOff),
    .storeData(storeData), .readWord(readWord),
    .writeMask(writeMask), .writeData(writeData), .loadValue(loadValue)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic st, logic [2:0] t, logic [1:0] off);
    @(posedge clk);
    storeEn = st; accType = t; byteOff = off;
    storeData = ST_PAT; readWord = RD_PAT;
    @(negedge clk);
  endtask

  function automatic logic [7:0] laneByte(logic [31:0] w, int idx);
    return (idx < 4) ? w[8*idx +: 8] : 8'h00;
  endfunction

  task automatic test_idle();
    @(negedge clk);
    check("R4 idle mask", {28'd0, writeMask}, 32'd0);
    check("R10 idle load", loadValue, 32'd0);
  endtask

  task automatic test_store_masks();
    logic [3:0] halfTbl [4] = '{4'b0011, 4'b0110, 4'b1100, 4'b1000};
    logic [3:0] wordTbl [4] = '{4'b1111, 4'b1110, 4'b1100, 4'b1000};
    for (int o = 0; o < 4; o++) begin
      apply(1'b1, 3'b000, o[1:0]);
      check("R1 byte mask", {28'd0, writeMask}, 32'(4'b0001 << o));
      apply(1'b1, 3'b001, o[1:0]);
      check("R2 half mask", {28'd0, writeMask}, {28'd0, halfTbl[o]});
      apply(1'b1, 3'b010, o[1:0]);
      check("R3 word mask", {28'd0, writeMask}, {28'd0, wordTbl[o]});
    end
  endtask

  task automatic test_no_store();
    for (int o = 0; o < 4; o++)
      for (int t = 0; t < 8; t++) begin
        apply(1'b0, t[2:0], o[1:0]);
        check("R4 gated mask", {28'd0, writeMask}, 32'd0);
      end
  endtask

  task automatic test_store_data();
    for (int o = 0; o < 4; o++) begin
      logic [31:0] exp;
      apply(1'b1, 3'b010, o[1:0]);
      exp = '0;
      for (int b = 0; b < 4; b++)
        if (b >= o) exp[8*b +: 8] = laneByte(ST_PAT, b - o);
      check("R5 store data", writeData, exp);
    end
  endtask

  task automatic test_byte_loads();
    for (int o = 0; o < 4; o++) begin
      logic [7:0] by;
      by = laneByte(RD_PAT, o);
      apply(1'b0, 3'b000, o[1:0]);
      check("R6 signed byte", loadValue, {{24{by[7]}}, by});
      apply(1'b0, 3'b100, o[1:0]);
      check("R7 unsigned byte", loadValue, {24'd0, by});
    end
  endtask

  task automatic test_half_loads();
    for (int o = 0; o < 4; o += 2) begin
      logic [15:0] h;
      h = {laneByte(RD_PAT, o + 1), laneByte(RD_PAT, o)};
      apply(1'b0, 3'b001, o[1:0]);
      check("R8 signed half", loadValue, {{16{h[15]}}, h});
      apply(1'b0, 3'b101, o[1:0]);
      check("R7 unsigned half", loadValue, {16'd0, h});
    end
  endtask

  task automatic test_word_loads();
    for (int o = 0; o < 4; o++) begin
      logic [31:0] exp;
      exp = '0;
      for (int b = 0; b < 4; b++) exp[8*b +: 8] = laneByte(RD_PAT, b + o);
      apply(1'b0, 3'b010, o[1:0]);
      check("R9 word load", loadValue, exp);
    end
  endtask

  task automatic test_unused_size();
    for (int o = 0; o < 4; o++) begin
      apply(1'b1, 3'b011, o[1:0]);
      check("R10 unused mask", {28'd0, writeMask}, 32'd0);
      check("R10 unused load", loadValue, 32'd0);
      apply(1'b1, 3'b111, o[1:0]);
      check("R10 unused load unsigned", loadValue, 32'd0);
    end
  endtask

  initial begin
    storeEn = 1'b0; accType = 3'b000; byteOff = 2'b00;
    storeData = '0; readWord = '0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    test_idle();
    test_store_masks();
    test_no_store();
    test_store_data();
    test_byte_loads();
    test_half_loads();
    test_word_loads();
    test_unused_size();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule